// File: doc/BRIEF.md
# Addressable Bidirectional Byte Port

This block joins a user-side 8-bit data bus to a controlling processor bus through one shared byte latch. The processor side is active low, the user side active high. The processor claims the port by placing an address on its bus during a select cycle. A select flag remembers whether the most recent address equalled the port's fixed address, which is set by a parameter. Once selected, the processor can write the latch or read it back. The user side writes and reads the same latch under its own two control inputs, and it wins when both sides write at once.

Both buses are modelled as separate input, output and output-enable signals. The strobe is a clock enable sampled on the rising edge of `clk`. A parameter chooses between two user-input variants. In the strobed variant, user writes need the strobe. In the free variant, user writes happen on any edge while the user input control is low. Because the processor bus is active low, a byte written from one side reads back inverted on the other side and unchanged on the side that wrote it.

Top module: `addr_io_port`

## Requirements
- R1: After reset the select flag is clear and the latch holds 0x00, so `host_oe` is low and a user read returns 0x00.
- R2: On an edge with `me_n`=0, `strobe`=1, `sel_cmd`=1 and `wr_cmd`=0, the select flag becomes 1 if `host_in` equals `PORT_ADDR` bit for bit, and 0 otherwise.
- R3: On an edge with `me_n`=0, `strobe`=1, `wr_cmd`=1, `sel_cmd`=0, the select flag set and `uin_n`=1, the latch takes the bitwise inverse of `host_in`.
- R4: On an edge with `me_n`=0, `strobe`=1 and both commands at 1, the latch takes the inverse of `host_in` whatever the select flag was (when `uin_n`=1). On the same edge the select flag is re-evaluated against that value as in R2.
- R5: While `uin_n`=0, no processor-side write reaches the latch, but processor-side address comparison still updates the select flag.
- R6: With `ASYNC_USER`=0 the latch takes `user_in` on an edge with `uin_n`=0 and `strobe`=1. With `ASYNC_USER`=1 it does so on any edge with `uin_n`=0, whatever the strobe.
- R7: `host_oe` is 1 exactly when `me_n`=0, both commands are 0 and the select flag is set. `host_out` is the inverse of the latch.
- R8: `user_oe` is 1 exactly when `uin_n`=1 and `uout_n`=0. `user_out` equals the latch.
- R9: While `me_n`=1 there is no select update, no processor-side write and no processor-side drive. The user side works unchanged.
- R10: On an edge with `strobe`=0 there is no processor-side latch write and no select update.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| me_n | input | 1 | Processor-side master enable, active low |
| sel_cmd | input | 1 | Select (address) command |
| wr_cmd | input | 1 | Write (data) command |
| strobe | input | 1 | Clock strobe enable |
| uin_n | input | 1 | User input control, active low |
| uout_n | input | 1 | User output control, active low |
| host_in | input | 8 | Processor bus value seen by the port |
| host_out | output | 8 | Processor bus value driven by the port |
| host_oe | output | 1 | Processor bus drive enable |
| user_in | input | 8 | User bus value seen by the port |
| user_out | output | 8 | User bus value driven by the port |
| user_oe | output | 1 | User bus drive enable |

## Verification
The hardest case to reach is a combined select-and-write cycle that arrives while the user side is also writing. The latch must then keep the user byte while the select flag still follows the address comparison. Directed steps build this case from a known select state: a mismatched combined cycle is followed by a read attempt, and the read shows that the flag cleared. Two instances run side by side, one for each user-input variant. A long random phase biases `host_in` toward the port address so that selects, deselects and contested writes happen often.

// File: rtl/addr_io_pkg.sv
package addr_io_pkg;
  localparam int PORT_W = 8;
  typedef logic [PORT_W-1:0] port_word_t;

  // Address compare on the raw processor-bus value.
  function automatic logic addr_hit(input port_word_t bus, input port_word_t own);
    return bus == own;
  endfunction

  // Polarity conversion between the active-low processor bus and the latch.
  function automatic port_word_t flip(input port_word_t v);
    return ~v;
  endfunction
endpackage

// File: rtl/sel_status.sv
module sel_status
  import addr_io_pkg::*;
#(
  parameter port_word_t OWN_ADDR = 8'h5A
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       upd,
  input  port_word_t bus,
  output logic       selected
);
  logic hit;
  assign hit = addr_hit(bus, OWN_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   selected <= 1'b0;
    else if (upd) selected <= hit;
  end

  p_sel_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && bus == OWN_ADDR) |=> selected);
  p_sel_clr_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (upd && bus != OWN_ADDR) |=> !selected);
  p_sel_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !upd |=> $stable(selected));
endmodule

// File: rtl/data_latch.sv
module data_latch
  import addr_io_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       take_user,
  input  logic       take_host,
  input  port_word_t user_d,
  input  port_word_t host_d,
  output port_word_t q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         q <= '0;
    else if (take_user) q <= user_d;
    else if (take_host) q <= flip(host_d);
  end

  p_user_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    take_user |=> q == $past(user_d));
  p_host_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (take_host && !take_user) |=> q == ~$past(host_d));
  p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!take_user && !take_host) |=> $stable(q));
endmodule

// File: rtl/addr_io_port.sv
module addr_io_port
  import addr_io_pkg::*;
#(
  parameter port_word_t PORT_ADDR  = 8'h5A,
  parameter bit         ASYNC_USER = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             me_n,
  input  logic             sel_cmd,
  input  logic             wr_cmd,
  input  logic             strobe,
  input  logic             uin_n,
  input  logic             uout_n,
  input  logic [PORT_W-1:0] host_in,
  output logic [PORT_W-1:0] host_out,
  output logic             host_oe,
  input  logic [PORT_W-1:0] user_in,
  output logic [PORT_W-1:0] user_out,
  output logic             user_oe
);
  // Named internal events
  logic       host_live;   // processor side enabled and strobed
  logic       sel_upd;     // address comparison this edge
  logic       user_take;   // user byte enters latch
  logic       host_take;   // processor byte enters latch
  logic       selected;
  port_word_t latch_q;

  assign host_live = !me_n && strobe;
  assign sel_upd   = host_live && sel_cmd;

  generate
    if (ASYNC_USER) begin : g_free_user
      assign user_take = !uin_n;
    end else begin : g_strobed_user
      assign user_take = !uin_n && strobe;
    end
  endgenerate

  assign host_take = host_live && wr_cmd && uin_n && (sel_cmd || selected);

  sel_status #(.OWN_ADDR(PORT_ADDR)) u_sel (
    .clk(clk), .rst_n(rst_n), .upd(sel_upd), .bus(host_in), .selected(selected)
  );

  data_latch u_latch (
    .clk(clk), .rst_n(rst_n), .take_user(user_take), .take_host(host_take),
    .user_d(user_in), .host_d(host_in), .q(latch_q)
  );

  assign host_oe  = !me_n && !sel_cmd && !wr_cmd && selected;
  assign host_out = flip(latch_q);
  assign user_oe  = uin_n && !uout_n;
  assign user_out = latch_q;

  p_host_drive_r7: assert property (@(posedge clk) disable iff (!rst_n)
    host_oe |-> (!me_n && !sel_cmd && !wr_cmd));
  p_me_block_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (me_n && uin_n) |=> ($stable(latch_q) && $stable(selected)));
  p_user_block_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!uin_n && !user_take) |=> $stable(latch_q));
  p_user_drive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    user_oe |-> uin_n);
endmodule

// File: tb/addr_io_port_test.sv
module addr_io_port_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] ADDR = 8'h5A;

  logic clk = 0, rst_n = 0;
  logic me_n = 1, sel_cmd = 0, wr_cmd = 0, strobe = 0, uin_n = 1, uout_n = 1;
  logic [7:0] host_in = 0, user_in = 0;
  logic [7:0] ho_s, uo_s, ho_a, uo_a;
  logic hoe_s, uoe_s, hoe_a, uoe_a;
  int checks = 0, errors = 0;
  bit done = 0;

  // Reference state: index 0 strobed variant, 1 free variant
  int m_sel [2];
  int m_lat [2];

  always #(CLK_PERIOD/2) clk = ~clk;

  addr_io_port #(.PORT_ADDR(ADDR), .ASYNC_USER(1'b0)) uut (
    .clk(clk), .rst_n(rst_n), .me_n(me_n), .sel_cmd(sel_cmd), .wr_cmd(wr_cmd),
    .strobe(strobe), .uin_n(uin_n), .uout_n(uout_n), .host_in(host_in),
    .host_out(ho_s), .host_oe(hoe_s), .user_in(user_in), .user_out(uo_s), .user_oe(uoe_s));

  addr_io_port #(.PORT_ADDR(ADDR), .ASYNC_USER(1'b1)) uut_async (
    .clk(clk), .rst_n(rst_n), .me_n(me_n), .sel_cmd(sel_cmd), .wr_cmd(wr_cmd),
    .strobe(strobe), .uin_n(uin_n), .uout_n(uout_n), .host_in(host_in),
    .host_out(ho_a), .host_oe(hoe_a), .user_in(user_in), .user_out(uo_a), .user_oe(uoe_a));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Compare both instances against the model (requirement tags in names).
  task automatic compare(input string tag);
    int hoe, uoe;
    for (int v = 0; v < 2; v++) begin
      hoe = (!me_n && !sel_cmd && !wr_cmd && m_sel[v] != 0) ? 1 : 0;
      uoe = (uin_n && !uout_n) ? 1 : 0;
      chk({tag, " R7 host_oe v", (v ? "1" : "0")}, v ? hoe_a : hoe_s, hoe);
      chk({tag, " R7 host_out"}, v ? ho_a : ho_s, (~m_lat[v]) & 8'hFF);
      chk({tag, " R8 user_oe"}, v ? uoe_a : uoe_s, uoe);
      chk({tag, " R8 user_out"}, v ? uo_a : uo_s, m_lat[v]);
    end
  endtask

  // Apply inputs away from the edge, update model at the edge, sample after.
  task automatic step(input bit me, input bit sc, input bit wc, input bit st,
                      input bit ui, input bit uo, input logic [7:0] hb,
                      input logic [7:0] ub, input string tag);
    bit host_ok, user_wr;
    me_n = me; sel_cmd = sc; wr_cmd = wc; strobe = st;
    uin_n = ui; uout_n = uo; host_in = hb; user_in = ub;
    @(posedge clk);
    host_ok = !me && st;
    for (int v = 0; v < 2; v++) begin
      user_wr = !ui && (v == 1 || st);
      if (user_wr) m_lat[v] = ub;
      else if (host_ok && wc && ui && (sc || m_sel[v] != 0)) m_lat[v] = (~hb) & 8'hFF;
      if (host_ok && sc) m_sel[v] = (hb == ADDR) ? 1 : 0;
    end
    #1;
    compare(tag);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int v = 0; v < 2; v++) begin m_sel[v] = 0; m_lat[v] = 0; end
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state, read attempts on both sides
    sel_cmd = 0; wr_cmd = 0; me_n = 0; uin_n = 1; uout_n = 0;
    #1 compare("R1 reset");
    @(negedge clk) rst_n = 1;
    // R2: wrong address clears, right address sets
    step(0,1,0,1,1,1, 8'h11, 8'h00, "R2 miss");
    step(0,0,0,0,1,0, 8'h00, 8'h00, "R2 read after miss");
    step(0,1,0,1,1,1, ADDR, 8'h00, "R2 hit");
    step(0,0,0,0,1,0, 8'h00, 8'h00, "R2 read after hit");
    // R3: selected write, read back both sides
    step(0,0,1,1,1,1, 8'h3C, 8'h00, "R3 write");
    step(0,0,0,0,1,0, 8'h00, 8'h00, "R3 readback");
    // R10: strobe low, write and miss address ignored
    step(0,0,1,0,1,1, 8'hF0, 8'h00, "R10 write no strobe");
    step(0,1,0,0,1,1, 8'h01, 8'h00, "R10 select no strobe");
    step(0,0,0,0,1,0, 8'h00, 8'h00, "R10 check");
    // R4: combined with mismatched address stores then deselects
    step(0,1,1,1,1,1, 8'h96, 8'h00, "R4 combined miss");
    step(0,0,0,0,1,0, 8'h00, 8'h00, "R4 check");
    // R4: combined write while deselected, matching address selects
    step(0,1,1,1,1,1, ADDR, 8'h00, "R4 combined hit");
    step(0,0,0,0,1,0, 8'h00, 8'h00, "R4 check hit");
    // R5: user wins, address still compared
    step(0,1,1,1,0,1, 8'h22, 8'hA5, "R5 contested");
    step(0,0,0,0,1,0, 8'h00, 8'h00, "R5 check");
    step(0,1,0,1,1,1, ADDR, 8'h00, "R5 reselect");
    step(0,0,1,1,0,1, 8'h44, 8'h77, "R5 write blocked");
    // R6: user write without strobe: only free variant takes it
    step(0,0,0,0,0,1, 8'h00, 8'hC3, "R6 user no strobe");
    step(0,0,0,0,1,0, 8'h00, 8'h00, "R6 check");
    step(0,0,0,1,0,1, 8'h00, 8'h18, "R6 user strobed");
    // R9: master enable high blocks processor side, not user side
    step(1,1,0,1,1,1, 8'h00, 8'h00, "R9 select blocked");
    step(1,0,1,1,1,1, 8'h0F, 8'h00, "R9 write blocked");
    step(1,0,0,0,1,0, 8'h00, 8'h00, "R9 no host drive");
    step(1,0,0,1,0,1, 8'h00, 8'h81, "R9 user works");
    step(0,0,0,0,1,0, 8'h00, 8'h00, "R9 check");
    // Mixed random traffic
    for (int i = 0; i < 400; i++) begin
      logic [7:0] hb;
      hb = ($urandom_range(0, 2) == 0) ? $urandom_range(0, 255) : ADDR;
      step($urandom_range(0, 5) == 0, $urandom_range(0, 1), $urandom_range(0, 1),
           $urandom_range(0, 3) != 0, $urandom_range(0, 3) != 0, $urandom_range(0, 1),
           hb, $urandom_range(0, 255), "MIX R2 R3 R4 R5");
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule